// File: doc/BRIEF.md
# Power-Management Companion Register Slave

This block is the register-mapped control slave of a power-management companion chip. A host bus reaches it through a 5-bit register index and a 16-bit data port. Each access is a single cycle, qualified by a valid strobe and a write flag, and read data is returned combinationally. The register file contains the following:

- an identification word;
- an interrupt source register, which a host can also clear;
- an interrupt mask;
- two general control words;
- a read-only status word;
- a watchdog word;
- an ADC channel selector, backed by a table of 10-bit per-channel sample values that are loaded from reset constants.

Event inputs for the power button, headset and hook set interrupt source bits. The headset and hook events also overwrite their own channel's sample. The block drives a level interrupt output and a sticky shutdown request. No analog conversion, timekeeping or audio function is included.

Top module: `pmic_regfile`

## Requirements
- R1: Reading index 0x00 returns 0x0215, with bit 7 also set while `variant_i` is high. Writes to this index are ignored.
- R2: `irq_o` is high exactly when some interrupt source bit is 1 and the matching mask bit (index 0x02, read/write, reset 0) is 0. A mask bit of 1 silences its source.
- R3: Interrupt source bit positions are: power button 0, hook 6, headset 7, ADC sample-done 8. Sources without an input (bits 1 to 5) stay 0. Index 0x01 reads the source bits zero-extended to 16 bits.
- R4: Writing index 0x01 clears every source bit written as 1, and `irq_o` follows after that same edge. If an event sets a bit in the same cycle that a write clears it, the set wins.
- R5: A write to index 0x08 takes the channel number from data bits 13:10 and sets source bit 8.
- R6: A read of index 0x08 returns the selected channel in bits 13:10 and that channel's 10-bit sample in bits 9:0, with bits 15:14 zero. The reset samples are: ch1 0x3C2, ch2 0x0FC, ch3 0x165, ch4 123, ch5 1023, ch6 0x11, ch7 0x11, ch8 0x250, ch10 2, ch11 0x11, ch12 0x3D0, ch13 0x330. All other channels are 0.
- R7: A headset event (channel 4, source 7) or hook event (channel 5, source 6) always loads its channel's sample with 50 if its state input is high, or 123 if it is low. It sets its source bit only when bits 8 and 10 of control word 1 (index 0x0D) are both 1.
- R8: A power button event sets source bit 0 and clears bit 5 of the status word (index 0x16, read-only, reset 0x0020).
- R9: Writing 0 to the watchdog (index 0x17) while bit 1 of control word 1 is 1 raises `shutdown_o`, which then stays high until reset. Other watchdog writes only store the value, which reads back.
- R10: An access with an index outside {0x00, 0x01, 0x02, 0x08, 0x0D, 0x0E, 0x16, 0x17} raises `bad_index_o` in that cycle, reads as 0, and changes no register.
- R11: Control words 1 and 2 (indices 0x0D, 0x0E) are 16-bit read/write, reset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| variant_i | input | 1 | Variant strap reflected in the identification word |
| acc_valid_i | input | 1 | Access strobe for this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_index_i | input | 5 | Register index |
| acc_wdata_i | input | 16 | Write data |
| acc_rdata_o | output | 16 | Read data (combinational) |
| bad_index_o | output | 1 | Access to an unmapped index |
| pwr_evt_i | input | 1 | Power button event pulse |
| head_evt_i | input | 1 | Headset event pulse |
| head_state_i | input | 1 | Headset state sampled with its event |
| hook_evt_i | input | 1 | Hook event pulse |
| hook_state_i | input | 1 | Hook state sampled with its event |
| irq_o | output | 1 | Level interrupt request |
| shutdown_o | output | 1 | Sticky shutdown request |

## Verification
The embedded assertions check the following on every cycle:

- a set source bit is present after its event;
- a host clear leaves no cleared bit behind unless an event set it again;
- an ADC write always raises source bit 8;
- the event samples take the 50/123 code;
- the shutdown request only rises on a guarded zero watchdog write and never falls;
- unmapped accesses leave the writable words untouched.

Only the bench scenarios can show the following:

- the exact read values, such as the identification word under both straps and the packed channel/sample word for every channel;
- the mask's effect on the interrupt level across all mask positions;
- the control-bit gating of headset and hook events;
- the set-over-clear ordering when an event and a clear share a cycle.

// File: rtl/pmic_pkg.sv
package pmic_pkg;

  localparam logic [4:0] IX_ID    = 5'h00;
  localparam logic [4:0] IX_SRC   = 5'h01;
  localparam logic [4:0] IX_MASK  = 5'h02;
  localparam logic [4:0] IX_ADC   = 5'h08;
  localparam logic [4:0] IX_CTL1  = 5'h0D;
  localparam logic [4:0] IX_CTL2  = 5'h0E;
  localparam logic [4:0] IX_STAT  = 5'h16;
  localparam logic [4:0] IX_WDOG  = 5'h17;

  localparam int SRC_PWR  = 0;
  localparam int SRC_HOOK = 6;
  localparam int SRC_HEAD = 7;
  localparam int SRC_ADC  = 8;

  localparam int CH_HEAD = 4;
  localparam int CH_HOOK = 5;

  localparam int CTL1_WDOG_ARM = 1;
  localparam int CTL1_ACC_A    = 8;
  localparam int CTL1_ACC_B    = 10;
  localparam int STAT_PWR_BIT  = 5;

  localparam logic [15:0] STAT_RESET = 16'h0020;
  localparam logic [15:0] ID_BASE    = 16'h0215;

  localparam logic [15:0] SAMPLE_ACTIVE   = 16'd50;
  localparam logic [15:0] SAMPLE_INACTIVE = 16'd123;

  // identification word, strap folded into bit 7
  function automatic logic [15:0] id_word(input logic variant);
    id_word = ID_BASE | {8'h00, variant, 7'h00};
  endfunction

  // reset value of one ADC channel sample
  function automatic logic [15:0] reset_sample(input int ch);
    case (ch)
      1:  reset_sample = 16'h03C2;
      2:  reset_sample = 16'h00FC;
      3:  reset_sample = 16'h0165;
      4:  reset_sample = 16'd123;
      5:  reset_sample = 16'd1023;
      6, 7, 11: reset_sample = 16'h0011;
      8:  reset_sample = 16'h0250;
      10: reset_sample = 16'h0002;
      12: reset_sample = 16'h03D0;
      13: reset_sample = 16'h0330;
      default: reset_sample = 16'h0000;
    endcase
  endfunction

  // sample loaded by an accessory event
  function automatic logic [15:0] event_sample(input logic state);
    event_sample = state ? SAMPLE_ACTIVE : SAMPLE_INACTIVE;
  endfunction

  function automatic logic index_mapped(input logic [4:0] ix);
    case (ix)
      IX_ID, IX_SRC, IX_MASK, IX_ADC,
      IX_CTL1, IX_CTL2, IX_STAT, IX_WDOG: index_mapped = 1'b1;
      default: index_mapped = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pmic_irq_ctrl.sv
module pmic_irq_ctrl #(
  parameter int NSRC = 9,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_bits_i,
  input  logic            mask_we_i,
  input  logic [DW-1:0]   mask_wdata_i,
  output logic [NSRC-1:0] src_o,
  output logic [DW-1:0]   mask_o,
  output logic            irq_o
);

  logic [NSRC-1:0] src_q;
  logic [DW-1:0]   mask_q;
  logic [NSRC-1:0] clr_eff;
  logic [NSRC-1:0] pending;

  assign clr_eff = clr_we_i ? clr_bits_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else begin
      src_q <= (src_q & ~clr_eff) | set_vec_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= mask_wdata_i;
    end
  end

  assign pending = src_q & ~mask_q[NSRC-1:0];
  assign irq_o   = |pending;
  assign src_o   = src_q;
  assign mask_o  = mask_q;

  // R3: every event-set bit is present the next cycle
  p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec_i != '0) |=> ((src_q & $past(set_vec_i)) == $past(set_vec_i)));

  // R4: cleared bits are gone unless set again in the same cycle
  p_clear_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((src_q & $past(clr_bits_i & ~set_vec_i)) == '0));

  // R2: with nothing pending the line is low
  p_mask_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[NSRC-1:0] == '1) |-> !irq_o);

endmodule

// File: rtl/pmic_adc_bank.sv
module pmic_adc_bank
  import pmic_pkg::*;
#(
  parameter int NCH = 16,
  parameter int SW  = 10,
  parameter int DW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_we_i,
  input  logic [CHW-1:0] sel_ch_i,
  input  logic           head_evt_i,
  input  logic           head_state_i,
  input  logic           hook_evt_i,
  input  logic           hook_state_i,
  output logic [DW-1:0]  rd_word_o
);

  logic [CHW-1:0] ch_q;
  logic [SW-1:0]  samp [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0;
    end else if (sel_we_i) begin
      ch_q <= sel_ch_i;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [SW-1:0] s_q;
    logic          ld;
    logic [SW-1:0] ld_val;

    if (g == CH_HEAD) begin : g_head
      assign ld     = head_evt_i;
      assign ld_val = SW'(event_sample(head_state_i));
    end else if (g == CH_HOOK) begin : g_hook
      assign ld     = hook_evt_i;
      assign ld_val = SW'(event_sample(hook_state_i));
    end else begin : g_fixed
      assign ld     = 1'b0;
      assign ld_val = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= SW'(reset_sample(g));
      end else if (ld) begin
        s_q <= ld_val;
      end
    end

    assign samp[g] = s_q;
  end

  always_comb begin
    rd_word_o = '0;
    rd_word_o[SW +: CHW] = ch_q;
    rd_word_o[SW-1:0]    = samp[ch_q];
  end

  // R7: event samples take the active/inactive code
  p_head_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    head_evt_i |=> (samp[CH_HEAD] == ($past(head_state_i) ? SW'(50) : SW'(123))));
  p_hook_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hook_evt_i |=> (samp[CH_HOOK] == ($past(hook_state_i) ? SW'(50) : SW'(123))));

  // R5: a selection write lands in the channel field
  p_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we_i |=> (rd_word_o[SW +: CHW] == $past(sel_ch_i)));

endmodule

// File: rtl/pmic_ctrl_regs.sv
module pmic_ctrl_regs
  import pmic_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wdata_i,
  input  logic          ctl1_we_i,
  input  logic          ctl2_we_i,
  input  logic          wdog_we_i,
  input  logic          pwr_evt_i,
  output logic [DW-1:0] ctl1_o,
  output logic [DW-1:0] ctl2_o,
  output logic [DW-1:0] wdog_o,
  output logic [DW-1:0] stat_o,
  output logic          acc_gate_o,
  output logic          shutdown_o
);

  logic [DW-1:0] ctl1_q, ctl2_q, wdog_q, stat_q;
  logic          shut_q;
  logic          wdog_kill;

  assign wdog_kill = wdog_we_i && (wdata_i == '0) && ctl1_q[CTL1_WDOG_ARM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q <= '0;
      ctl2_q <= '0;
      wdog_q <= '0;
    end else begin
      if (ctl1_we_i) ctl1_q <= wdata_i;
      if (ctl2_we_i) ctl2_q <= wdata_i;
      if (wdog_we_i) wdog_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= DW'(STAT_RESET);
    end else if (pwr_evt_i) begin
      stat_q[STAT_PWR_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q <= 1'b0;
    end else if (wdog_kill) begin
      shut_q <= 1'b1;
    end
  end

  assign ctl1_o     = ctl1_q;
  assign ctl2_o     = ctl2_q;
  assign wdog_o     = wdog_q;
  assign stat_o     = stat_q;
  assign acc_gate_o = ctl1_q[CTL1_ACC_A] & ctl1_q[CTL1_ACC_B];
  assign shutdown_o = shut_q;

  // R9: shutdown never drops and only rises on a guarded zero write
  p_shutdown_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |=> shutdown_o);
  p_shutdown_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_o) |-> $past(wdog_we_i && (wdata_i == '0) && ctl1_q[CTL1_WDOG_ARM]));

  // R8: power event clears the status flag
  p_pwr_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_evt_i |=> !stat_o[STAT_PWR_BIT]);

endmodule

// File: rtl/pmic_regfile.sv
module pmic_regfile
  import pmic_pkg::*;
#(
  parameter int NSRC = 9,
  parameter int NCH  = 16,
  parameter int SW   = 10,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          variant_i,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic [4:0]    acc_index_i,
  input  logic [DW-1:0] acc_wdata_i,
  output logic [DW-1:0] acc_rdata_o,
  output logic          bad_index_o,
  input  logic          pwr_evt_i,
  input  logic          head_evt_i,
  input  logic          head_state_i,
  input  logic          hook_evt_i,
  input  logic          hook_state_i,
  output logic          irq_o,
  output logic          shutdown_o
);

  localparam int CHW = $clog2(NCH);

  logic            mapped, wr, rd;
  logic            src_we, mask_we, adc_we, ctl1_we, ctl2_we, wdog_we;
  logic [NSRC-1:0] set_vec, src;
  logic [DW-1:0]   mask, ctl1, ctl2, wdog, stat, adc_word;
  logic            acc_gate;

  assign mapped      = index_mapped(acc_index_i);
  assign bad_index_o = acc_valid_i && !mapped;
  assign wr          = acc_valid_i && acc_write_i && mapped;
  assign rd          = acc_valid_i && !acc_write_i && mapped;

  assign src_we  = wr && (acc_index_i == IX_SRC);
  assign mask_we = wr && (acc_index_i == IX_MASK);
  assign adc_we  = wr && (acc_index_i == IX_ADC);
  assign ctl1_we = wr && (acc_index_i == IX_CTL1);
  assign ctl2_we = wr && (acc_index_i == IX_CTL2);
  assign wdog_we = wr && (acc_index_i == IX_WDOG);

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_PWR]  = pwr_evt_i;
    set_vec[SRC_HOOK] = hook_evt_i && acc_gate;
    set_vec[SRC_HEAD] = head_evt_i && acc_gate;
    set_vec[SRC_ADC]  = adc_we;
  end

  pmic_irq_ctrl #(.NSRC(NSRC), .DW(DW)) irq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_vec_i    (set_vec),
    .clr_we_i     (src_we),
    .clr_bits_i   (acc_wdata_i[NSRC-1:0]),
    .mask_we_i    (mask_we),
    .mask_wdata_i (acc_wdata_i),
    .src_o        (src),
    .mask_o       (mask),
    .irq_o        (irq_o)
  );

  pmic_adc_bank #(.NCH(NCH), .SW(SW), .DW(DW)) adc_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_we_i     (adc_we),
    .sel_ch_i     (acc_wdata_i[SW +: CHW]),
    .head_evt_i   (head_evt_i),
    .head_state_i (head_state_i),
    .hook_evt_i   (hook_evt_i),
    .hook_state_i (hook_state_i),
    .rd_word_o    (adc_word)
  );

  pmic_ctrl_regs #(.DW(DW)) ctl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdata_i    (acc_wdata_i),
    .ctl1_we_i  (ctl1_we),
    .ctl2_we_i  (ctl2_we),
    .wdog_we_i  (wdog_we),
    .pwr_evt_i  (pwr_evt_i),
    .ctl1_o     (ctl1),
    .ctl2_o     (ctl2),
    .wdog_o     (wdog),
    .stat_o     (stat),
    .acc_gate_o (acc_gate),
    .shutdown_o (shutdown_o)
  );

  always_comb begin
    acc_rdata_o = '0;
    if (rd) begin
      case (acc_index_i)
        IX_ID:   acc_rdata_o = DW'(id_word(variant_i));
        IX_SRC:  acc_rdata_o = DW'(src);
        IX_MASK: acc_rdata_o = mask;
        IX_ADC:  acc_rdata_o = adc_word;
        IX_CTL1: acc_rdata_o = ctl1;
        IX_CTL2: acc_rdata_o = ctl2;
        IX_STAT: acc_rdata_o = stat;
        IX_WDOG: acc_rdata_o = wdog;
        default: acc_rdata_o = '0;
      endcase
    end
  end

  // R5: an ADC write always raises sample-done
  p_adc_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_we |=> src[SRC_ADC]);

  // R10: unmapped access leaves writable words alone
  p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_index_o |=> ($stable(mask) && $stable(ctl1) && $stable(ctl2) && $stable(wdog)));

  // R7: ungated headset event cannot raise its source
  p_head_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (head_evt_i && !acc_gate && !src[SRC_HEAD]) |=> !src[SRC_HEAD]);

endmodule

// File: tb/pmic_regfile_tb.sv
module pmic_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        variant = 1'b0;
  logic        vld = 1'b0, wen = 1'b0;
  logic [4:0]  idx = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        bad, irq, shut;
  logic        pwr = 1'b0, head = 1'b0, head_st = 1'b0, hook = 1'b0, hook_st = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pmic_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .variant_i(variant),
    .acc_valid_i(vld), .acc_write_i(wen), .acc_index_i(idx), .acc_wdata_i(wd),
    .acc_rdata_o(rdata), .bad_index_o(bad),
    .pwr_evt_i(pwr), .head_evt_i(head), .head_state_i(head_st),
    .hook_evt_i(hook), .hook_state_i(hook_st),
    .irq_o(irq), .shutdown_o(shut)
  );

  function automatic logic [15:0] exp_sample(input int ch);
    if (ch == 1) return 16'd962;
    if (ch == 2) return 16'd252;
    if (ch == 3) return 16'd357;
    if (ch == 4) return 16'd123;
    if (ch == 5) return 16'd1023;
    if (ch == 6 || ch == 7 || ch == 11) return 16'd17;
    if (ch == 8) return 16'd592;
    if (ch == 10) return 16'd2;
    if (ch == 12) return 16'd976;
    if (ch == 13) return 16'd816;
    return 16'd0;
  endfunction

  function automatic bit exp_mapped(input int i);
    return i == 0 || i == 1 || i == 2 || i == 8 || i == 13 || i == 14 || i == 22 || i == 23;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [15:0] d);
    @(negedge clk);
    vld = 1'b1; wen = 1'b1; idx = 5'(i); wd = d;
    @(negedge clk);
    vld = 1'b0; wen = 1'b0;
  endtask

  task automatic rd(input int i, output logic [15:0] d, output logic b);
    @(negedge clk);
    vld = 1'b1; wen = 1'b0; idx = 5'(i);
    #1;
    d = rdata; b = bad;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic pulse(input int which, input logic st);
    @(negedge clk);
    case (which)
      0: pwr = 1'b1;
      1: begin head = 1'b1; head_st = st; end
      default: begin hook = 1'b1; hook_st = st; end
    endcase
    @(negedge clk);
    pwr = 1'b0; head = 1'b0; hook = 1'b0;
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic        b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state
    check("R2 reset irq", 16'(irq), 16'd0);
    check("R9 reset shutdown", 16'(shut), 16'd0);
    rd(22, v, b); check("R8 status reset", v, 16'h0020);
    rd(1, v, b);  check("R3 sources reset", v, 16'h0000);

    // R1 identification under both straps, write ignored
    for (int s = 0; s < 2; s++) begin
      variant = 1'(s);
      rd(0, v, b); check("R1 id", v, 16'h0215 + 16'(s * 128));
    end
    wr(0, 16'hFFFF);
    rd(0, v, b); check("R1 id after write", v, 16'h0295);
    variant = 1'b0;

    // R10 index sweep
    for (int i = 0; i < 32; i++) begin
      rd(i, v, b);
      check("R10 bad flag", 16'(b), 16'(!exp_mapped(i)));
      if (!exp_mapped(i)) check("R10 unmapped read", v, 16'h0000);
    end
    for (int i = 0; i < 32; i++) begin
      if (!exp_mapped(i)) wr(i, 16'hFFFF);
    end
    rd(2, v, b);  check("R10 mask untouched", v, 16'h0000);
    rd(13, v, b); check("R10 ctl1 untouched", v, 16'h0000);
    rd(23, v, b); check("R10 wdog untouched", v, 16'h0000);
    check("R10 irq untouched", 16'(irq), 16'd0);

    // R5 / R6 channel sweep
    for (int c = 0; c < 16; c++) begin
      wr(8, 16'(c * 1024) | 16'h03FF);
      rd(8, v, b); check("R6 adc word", v, 16'(c * 1024) + exp_sample(c));
      rd(1, v, b); check("R5 sample-done", v, 16'h0100);
      check("R2 irq on adc", 16'(irq), 16'd1);
    end

    // R4 clear
    wr(1, 16'h0100);
    check("R4 irq after clear", 16'(irq), 16'd0);
    rd(1, v, b); check("R4 sources cleared", v, 16'h0000);

    // R2 mask sweep with only bit 8 pending
    wr(8, 16'h0000);
    for (int m = 0; m < 16; m++) begin
      wr(2, 16'(1 << m));
      check("R2 mask level", 16'(irq), 16'(m != 8));
    end
    rd(2, v, b); check("R2 mask readback", v, 16'h8000);
    wr(2, 16'h0000);
    wr(1, 16'hFFFF);

    // R7 gating
    pulse(1, 1'b1);
    rd(1, v, b); check("R7 head ungated", v, 16'h0000);
    wr(8, 16'h1000);
    rd(8, v, b); check("R7 head sample active", v, 16'h1000 + 16'd50);
    wr(13, 16'h0100);
    pulse(2, 1'b1);
    wr(1, 16'h0100);
    rd(1, v, b); check("R7 hook half-gated", v, 16'h0000);
    wr(13, 16'h0500);
    pulse(1, 1'b0);
    rd(1, v, b); check("R7 head gated", v, 16'h0080);
    pulse(2, 1'b0);
    rd(1, v, b); check("R7 hook gated", v, 16'h00C0);
    wr(8, 16'h1400);
    rd(8, v, b); check("R7 hook sample inactive", v, 16'h1400 + 16'd123);
    wr(8, 16'h1000);
    rd(8, v, b); check("R7 head sample inactive", v, 16'h1000 + 16'd123);
    wr(1, 16'h01FF);

    // R8 / R3 power event
    pulse(0, 1'b0);
    rd(1, v, b);  check("R3 power bit", v, 16'h0001);
    rd(22, v, b); check("R8 status cleared", v, 16'h0000);
    wr(22, 16'hFFFF);
    rd(22, v, b); check("R8 status read-only", v, 16'h0000);

    // R4 set wins over clear in the same cycle
    @(negedge clk);
    vld = 1'b1; wen = 1'b1; idx = 5'd1; wd = 16'h0001; pwr = 1'b1;
    @(negedge clk);
    vld = 1'b0; wen = 1'b0; pwr = 1'b0;
    rd(1, v, b); check("R4 set beats clear", v, 16'h0001);
    wr(1, 16'h0001);
    check("R4 irq after power clear", 16'(irq), 16'd0);

    // R11 control words
    wr(14, 16'hA5C3);
    rd(14, v, b); check("R11 ctl2", v, 16'hA5C3);
    rd(13, v, b); check("R11 ctl1", v, 16'h0500);

    // R9 watchdog
    wr(23, 16'h0000);
    check("R9 unarmed zero", 16'(shut), 16'd0);
    wr(23, 16'h1234);
    rd(23, v, b); check("R9 wdog readback", v, 16'h1234);
    wr(13, 16'h0002);
    wr(23, 16'h0005);
    check("R9 armed nonzero", 16'(shut), 16'd0);
    wr(23, 16'h0000);
    check("R9 armed zero", 16'(shut), 16'd1);
    wr(13, 16'h0000);
    wr(23, 16'h0042);
    check("R9 sticky", 16'(shut), 16'd1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule